// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a countdown watchdog that sits on a simple register bus and is driven through a single 32-bit configuration word. Every write to the word stores a new 24-bit reload value. Two small 2-bit key fields in the same word turn the timer on or off and restart it. A key field takes effect only when one write places the arming code in it and the very next write to the word places the firing code there. A stray or single write cannot stop or feed the watchdog by accident.

Once running, the timer divides the bus clock by 256 and decrements its count on every divided tick. When the count runs out, the block raises a one-cycle reset request and starts a new period at once. Software must complete the restart key sequence more often than once per period. The enable key toggles the running state rather than setting it, so software reads the status bit first to learn the current state.

The bus has no back-pressure: a write is taken in the cycle `bus_wr` is high, and `bus_rdata` always shows the current contents of the word.

Top module: `wdog_keyed`

## Requirements
- R1: After reset the status bit reads 0, the reload value reads 0, `rst_req` is low and neither key field is armed.
- R2: Every write copies `bus_wdata[23:0]` into the reload value, which reads back on `bus_rdata[23:0]` from the next cycle. `bus_rdata[30:24]` read 0, and written values in bits 31:28 are ignored.
- R3: The toggle key sits in bits 25:24. A write of code 1 followed by a next write of code 2 in that field flips the status bit, `bus_rdata[31]` (1 = running).
- R4: An armed key field that receives any value other than 2 on the next write (0 or 3) is disarmed with no action. A value of 1 arms the field again.
- R5: Writing 0, 2 or 3 into a key field that is not armed changes nothing.
- R6: When the timer turns on, the count loads from the reload value carried by that write and the divider clears. The first `rst_req` pulse comes exactly 256 × reload cycles after the clock edge that took the write.
- R7: On expiry `rst_req` is high for exactly one cycle and the count reloads. With no restart, pulses repeat every 256 × reload cycles.
- R8: The restart key sits in bits 27:26 and uses the same 1-then-2 sequence. Completing it while the timer runs loads the count from that write's reload value and clears the divider. The next pulse comes 256 × reload cycles after that write.
- R9: While the status bit is 0, `rst_req` stays low and the count and divider do not advance.
- R10: A reload value of 0 acts as 1, giving a period of 256 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the configuration word, always accepted |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Current word: status at bit 31, reload value at 23:0 |
| rst_req | output | 1 | One-cycle reset request on expiry |

## Verification
The assertions assume that `bus_wr` stays low for as long as `rst_n` is low. They also assume that `bus_wdata` holds defined values in every cycle in which `bus_wr` is high, because the reload capture and status-hold properties sample it there. The stimulus releases reset before its first write and changes the bus only on the falling clock edge. Each write lasts exactly one cycle, so every key sequence completes on two consecutive writes.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int CFG_W      = 32;
  localparam int RELOAD_W   = 24;
  localparam int KEY_W      = 2;
  localparam int TOGGLE_LSB = 24;
  localparam int RESTART_LSB = TOGGLE_LSB + KEY_W;
  localparam int STATUS_BIT = 31;
  localparam int N_KEYS     = 2;

  localparam logic [KEY_W-1:0] KEY_ARM  = 2'd1;
  localparam logic [KEY_W-1:0] KEY_FIRE = 2'd2;
endpackage

// File: rtl/wdog_key_track.sv
module wdog_key_track
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [KEY_W-1:0] code,
  output logic             done
);
  logic armed_q;

  assign done = wr && armed_q && (code == KEY_FIRE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else if (wr) begin
      armed_q <= (code == KEY_ARM);
    end
  end
endmodule

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clear,
  output logic tick
);
  logic [W-1:0] cnt_q;

  assign tick = run && (cnt_q == '1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (run) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  input  logic [W-1:0] reload_val,
  output logic         expire_q
);
  logic [W-1:0] cnt_q;
  logic         last;

  assign last = (cnt_q <= W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      expire_q <= 1'b0;
    end else begin
      expire_q <= 1'b0;
      if (load) begin
        cnt_q <= load_val;
      end else if (tick) begin
        if (last) begin
          cnt_q    <= reload_val;
          expire_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
  import wdog_pkg::*;
#(
  parameter int PRESCALE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [CFG_W-1:0] bus_wdata,
  output logic [CFG_W-1:0] bus_rdata,
  output logic             rst_req
);
  localparam int PAD_W = STATUS_BIT - RELOAD_W;

  logic [RELOAD_W-1:0] reload_q;
  logic                run_q;
  logic [N_KEYS-1:0]   key_done;
  logic                toggle_done;
  logic                restart_done;
  logic                turn_on;
  logic                restart;
  logic                tick;
  logic                wdata_unused;

  assign wdata_unused = ^bus_wdata[CFG_W-1:RESTART_LSB+KEY_W];

  for (genvar g = 0; g < N_KEYS; g++) begin : g_key
    wdog_key_track u_track (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (bus_wr),
      .code  (bus_wdata[TOGGLE_LSB + KEY_W*g +: KEY_W]),
      .done  (key_done[g])
    );
  end

  assign toggle_done  = key_done[0];
  assign restart_done = key_done[1];
  assign turn_on      = toggle_done && !run_q;
  assign restart      = turn_on || (restart_done && run_q && !toggle_done);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload_q <= '0;
      run_q    <= 1'b0;
    end else begin
      if (bus_wr) reload_q <= bus_wdata[RELOAD_W-1:0];
      if (toggle_done) run_q <= !run_q;
    end
  end

  wdog_prescale #(.W(PRESCALE_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run_q),
    .clear (restart),
    .tick  (tick)
  );

  wdog_countdown #(.W(RELOAD_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (restart),
    .load_val   (bus_wdata[RELOAD_W-1:0]),
    .tick       (tick),
    .reload_val (reload_q),
    .expire_q   (rst_req)
  );

  assign bus_rdata = {run_q, {PAD_W{1'b0}}, reload_q};
endmodule

// File: rtl/wdog_keyed_chk.sv
module wdog_keyed_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic        rst_req
);
  p_pulse_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  p_quiet_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rdata[31] |=> !rst_req);

  p_status_needs_fire_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr || bus_wdata[25:24] != 2'd2) |=> $stable(bus_rdata[31]));

  p_reload_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |=> (bus_rdata[23:0] == $past(bus_wdata[23:0])));

  p_reload_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(bus_rdata[23:0]));

  p_pad_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |=> (bus_rdata[30:24] == 7'd0));
endmodule

bind wdog_keyed wdog_keyed_chk u_chk (.*);

// File: tb/wdog_keyed_bench.sv
module wdog_keyed_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rst_req;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  wdog_keyed u_wdog_keyed (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .rst_req   (rst_req)
  );

  // rows: {write data, expected read-back}; covers R2 R3 R4 R5
  localparam int NV = 14;
  localparam logic [63:0] VEC [NV] = '{
    {32'h0000_0005, 32'h0000_0005},  // R2 plain reload
    {32'h0100_0003, 32'h0000_0003},  // arm toggle
    {32'h0000_0004, 32'h0000_0004},  // R4 disarm by 0
    {32'h0200_0004, 32'h0000_0004},  // R5 fire without arm
    {32'h0300_0006, 32'h0000_0006},  // R5 code 3
    {32'h0100_0006, 32'h0000_0006},  // arm
    {32'h0200_0007, 32'h8000_0007},  // R3 turn on
    {32'h7F00_0007, 32'h8000_0007},  // R2 upper bits ignored
    {32'h0100_0009, 32'h8000_0009},  // arm
    {32'h0100_0009, 32'h8000_0009},  // R4 re-arm
    {32'h0200_0009, 32'h0000_0009},  // R3 turn off
    {32'h0100_000A, 32'h0000_000A},  // arm
    {32'h0300_000A, 32'h0000_000A},  // R4 disarm by 3
    {32'h0200_000A, 32'h0000_000A}   // no toggle
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [31:0] d);
    @(negedge clk);
    bus_wr    = 1'b1;
    bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr    = 1'b0;
    bus_wdata = '0;
  endtask

  // waits for the first pulse counting edges from the last write, then checks width
  task automatic expect_req(input int exp_c, input string tag);
    int first = -1;
    int c = 0;
    while (first < 0 && c < exp_c + 300) begin
      @(posedge clk);
      @(negedge clk);
      c++;
      if (rst_req) first = c;
    end
    check({tag, " pulse cycle"}, first, exp_c);
    @(posedge clk);
    @(negedge clk);
    check("R7 pulse width", {31'd0, rst_req}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog act=hung exp=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rdata after reset", bus_rdata, 32'd0);
    check("R1 rst_req after reset", {31'd0, rst_req}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      do_write(VEC[i][63:32]);
      check($sformatf("R2 R3 R4 R5 row %0d rdata", i), bus_rdata, VEC[i][31:0]);
      check($sformatf("R9 row %0d rst_req", i), {31'd0, rst_req}, 32'd0);
    end

    // R6 turn on with reload 2, then R7 periodic
    do_write(32'h0100_0002);
    do_write(32'h0200_0002);
    check("R3 status on", bus_rdata, 32'h8000_0002);
    expect_req(512, "R6");
    expect_req(511, "R7");

    // R8 restart mid-period with reload 3
    repeat (100) @(negedge clk);
    do_write(32'h0400_0003);
    do_write(32'h0800_0003);
    expect_req(768, "R8");

    // R9 turn off, no pulses
    do_write(32'h0100_0003);
    do_write(32'h0200_0003);
    check("R3 status off", bus_rdata, 32'h0000_0003);
    begin
      int highs = 0;
      for (int k = 0; k < 1000; k++) begin
        @(negedge clk);
        if (rst_req) highs++;
      end
      check("R9 no pulse while off", highs, 0);
    end

    // R6 re-enable restarts full period
    do_write(32'h0100_0001);
    do_write(32'h0200_0001);
    expect_req(256, "R6 re-enable");

    // R10 reload zero
    do_write(32'h0100_0001);
    do_write(32'h0200_0001);
    check("R3 status off again", bus_rdata, 32'h0000_0001);
    do_write(32'h0100_0000);
    do_write(32'h0200_0000);
    expect_req(256, "R10");
    expect_req(255, "R10 repeat");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule